// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block keeps the status byte of a small serial EEPROM and rules on every write the command decoder asks for, whether it targets the status byte or the memory array. Three protection layers feed one decision. The first is a volatile write-enable latch. The second is a block-protect field that guards the top quarter, the top half or the whole array. The third is a hardware lock on the status byte, armed by a lock-enable bit together with a low level on the write-protect pin.

The command decoder presents one strobe per clock, for one of five commands: enable writes, disable writes, read status, write status and write memory. A memory write comes with an address and a status write comes with a data byte. The internal write engine reports its activity on `busy`. The block answers one clock after the strobe with three registered outputs: an accept pulse, a write-permitted pulse and the status byte.

A small state machine has three states. ST_IDLE means ready. ST_PEND means a write was granted and the engine has not yet raised `busy`. ST_CYCLE means the engine is running. The transitions are:
- GRANT: ST_IDLE to ST_PEND, taken on a permitted write.
- LAUNCH: ST_PEND to ST_CYCLE, taken when `busy` rises.
- FINISH: ST_CYCLE to ST_IDLE, taken when `busy` falls. This transition clears the write-enable latch.
- POWER_UP: any state to ST_IDLE, taken on `pwr_up`.

The lock-enable bit and the block-protect field model non-volatile cells. They return to 0 only on the hard reset `rst_n` and are kept through the soft power-up `pwr_up`.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After `rst_n` the status byte reads 8'h00: lock-enable 0, block-protect 00, write-enable 0, ready.
- R2: The status byte is laid out as bit 7 lock-enable, bits 3:2 block-protect, bit 1 write-enable and bit 0 busy. Bits 6:4 ignore written data and always read 0.
- R3: While the block is not ready (`busy` high or state not ST_IDLE), a status read is accepted and returns 8'hFF. Every other command gets no accept pulse and has no effect.
- R4: The write-enable bit is set only by the enable-writes command. It is cleared by the disable-writes command, by `pwr_up` and by the FINISH transition.
- R5: With write-enable 0, every memory write and every status write is refused (`cmd_ack`=1, `wr_allow`=0).
- R6: With MEM_BYTES=4096, block-protect 00 guards nothing, 01 guards 0C00h-0FFFh, 10 guards 0800h-0FFFh and 11 guards the whole array. A memory write to a guarded address is refused even with write-enable 1. With MEM_BYTES=8192 the 01 and 10 ranges start at 1800h and 1000h.
- R7: When `wp_n` is 0 and lock-enable is 1, status writes are refused, but memory writes are still allowed.
- R8: Lock-enable can go from 1 to 0 only while `wp_n` is 1.
- R9: `pwr_up` keeps lock-enable and block-protect and clears write-enable.
- R10: `cmd_ack`, `wr_allow` and `sr_rd` update one clock after the strobe. `cmd_ack` and `wr_allow` are single-cycle pulses.
- R11: A permitted write (GRANT) makes the block not ready until the FINISH transition. Status reads in between return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low; clears every bit |
| pwr_up | input | 1 | Soft power-up pulse; clears write-enable only |
| cmd_wren | input | 1 | Enable-writes command strobe |
| cmd_wrdi | input | 1 | Disable-writes command strobe |
| cmd_rdsr | input | 1 | Read-status command strobe |
| cmd_wrsr | input | 1 | Write-status command strobe |
| cmd_write | input | 1 | Memory-write command strobe |
| wr_addr | input | AW | Memory-write byte address |
| sr_din | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write engine running |
| sr_rd | output | 8 | Status byte from the last status read |
| wr_allow | output | 1 | Pulse: the write was permitted |
| cmd_ack | output | 1 | Pulse: the command was accepted |

## Verification
The bench probes the address just below and just at each block-protect boundary. A design that decoded a range off by one bit would grant or refuse the wrong side of a boundary.

It tries to clear lock-enable with `wp_n` both low and high. A design missing the one-way lock would drop the hardware lock while the pin is low.

It issues commands while `busy` is high and also in the gap before the engine starts. A design that only watched `busy` would accept commands during ST_PEND, and one that did not force 8'hFF would leak the real status byte.

It also checks that write-enable survives a refused write and that it is cleared by completion and by `pwr_up`. A design that lost the non-volatile bits on `pwr_up`, or left write-enable set after a cycle, is caught by readback.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_CYCLE = 2'd2
    } wp_state_e;

    localparam int SR_W       = 8;
    localparam int BIT_LOCK   = 7;
    localparam int BIT_BP_HI  = 3;
    localparam int BIT_BP_LO  = 2;
    localparam logic [SR_W-1:0] SR_BUSY_VAL = '1;

    function automatic logic [SR_W-1:0] pack_sr(input logic lock, input logic [1:0] bp,
                                                 input logic wen, input logic rdy);
        pack_sr = {lock, 3'b000, bp, wen, rdy};
    endfunction
endpackage

// File: rtl/wp_block_decode.sv
module wp_block_decode #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bp_i,
    input  logic [AW-1:0] addr_i,
    output logic          prot_o
);
    always_comb begin
        unique case (bp_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = (addr_i[AW-1:AW-2] == 2'b11);
            2'b10:   prot_o = addr_i[AW-1];
            default: prot_o = 1'b1;
        endcase
    end

    // R6: full protection guards every address
    a_r6_full_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_i == 2'b11) |-> prot_o);
    // R6: no protection guards nothing
    a_r6_none_open: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_i == 2'b00) |-> !prot_o);
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up,
    input  logic       set_wen,
    input  logic       clr_wen,
    input  logic       sr_load,
    input  logic [7:0] din,
    input  logic       wp_n,
    output logic       lock_o,
    output logic [1:0] bp_o,
    output logic       wen_o
);
    import wp_pkg::*;

    logic lock_q, wen_q;
    logic [1:0] bp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            bp_q   <= 2'b00;
            wen_q  <= 1'b0;
        end else begin
            if (pwr_up || clr_wen)
                wen_q <= 1'b0;
            else if (set_wen)
                wen_q <= 1'b1;
            if (sr_load) begin
                bp_q <= din[BIT_BP_HI:BIT_BP_LO];
                if (!(lock_q && !wp_n))
                    lock_q <= din[BIT_LOCK];
            end
        end
    end

    assign lock_o = lock_q;
    assign bp_o   = bp_q;
    assign wen_o  = wen_q;

    // R8: lock-enable never falls while the pin holds it
    a_r8_lock_oneway: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_n) |=> lock_q);
    // R9: soft power-up leaves write-enable cleared
    a_r9_pwrup_wen: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> !wen_q);
    // R9: soft power-up keeps block-protect
    a_r9_pwrup_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && !sr_load) |=> $stable(bp_q));
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl #(
    parameter int MEM_BYTES = 4096,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_up,
    input  logic          cmd_wren,
    input  logic          cmd_wrdi,
    input  logic          cmd_rdsr,
    input  logic          cmd_wrsr,
    input  logic          cmd_write,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    sr_din,
    input  logic          wp_n,
    input  logic          busy,
    output logic [7:0]    sr_rd,
    output logic          wr_allow,
    output logic          cmd_ack
);
    import wp_pkg::*;

    wp_state_e state_q, state_d;
    logic lock, wen, prot, hwp, rdy, take;
    logic arr_ok, sr_ok, start, set_wen, clr_wen, finish;
    logic [1:0] bp;

    assign rdy     = busy || (state_q != ST_IDLE);
    assign take    = !rdy;
    assign hwp     = lock && !wp_n;
    assign arr_ok  = cmd_write && take && wen && !prot;
    assign sr_ok   = cmd_wrsr && take && wen && !hwp;
    assign start   = arr_ok || sr_ok;
    assign finish  = (state_q == ST_CYCLE) && !busy;
    assign set_wen = cmd_wren && take;
    assign clr_wen = (cmd_wrdi && take) || finish;

    wp_status_regs u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
        .set_wen(set_wen), .clr_wen(clr_wen), .sr_load(sr_ok),
        .din(sr_din), .wp_n(wp_n),
        .lock_o(lock), .bp_o(bp), .wen_o(wen)
    );

    wp_block_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .bp_i(bp), .addr_i(wr_addr), .prot_o(prot)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PEND;
            ST_PEND:  if (busy)  state_d = ST_CYCLE;
            ST_CYCLE: if (!busy) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (pwr_up) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_rd    <= '0;
            wr_allow <= 1'b0;
            cmd_ack  <= 1'b0;
        end else begin
            wr_allow <= start;
            cmd_ack  <= cmd_rdsr || (take && (cmd_wren || cmd_wrdi || cmd_wrsr || cmd_write));
            if (cmd_rdsr)
                sr_rd <= rdy ? SR_BUSY_VAL : pack_sr(lock, bp, wen, 1'b0);
        end
    end

    // R5: a permitted write needs write-enable set at the strobe
    a_r5_allow_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> $past(wen));
    // R3: nothing is permitted while the engine runs
    a_r3_busy_no_allow: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !wr_allow);
    // R11: finishing a cycle clears write-enable
    a_r11_finish_clears: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !wen);
    // R2: unused bits read 0 unless the busy pattern is shown
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd == SR_BUSY_VAL) || (sr_rd[6:4] == 3'b000));
    // R10: permitted-write flag is a single pulse
    a_r10_allow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |=> !wr_allow);
endmodule

// File: tb/eeprom_wp_ctrl_tb.sv
`timescale 1ns/1ps
module eeprom_wp_ctrl_tb;
    localparam int MEM_BYTES = 4096;
    localparam int AW = $clog2(MEM_BYTES);
    localparam int C_WREN = 0, C_WRDI = 1, C_RDSR = 2, C_WRSR = 3, C_WRITE = 4;

    logic clk = 0, rst_n = 0, pwr_up = 0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] sr_din = '0;
    logic wp_n = 1, busy = 0;
    logic [7:0] sr_rd;
    logic wr_allow, cmd_ack;

    int n_chk = 0, n_bad = 0;
    logic g_ack, g_allow;
    logic [7:0] g_sr;

    always #2.5 clk = ~clk;

    eeprom_wp_ctrl #(.MEM_BYTES(MEM_BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write),
        .wr_addr(wr_addr), .sr_din(sr_din), .wp_n(wp_n), .busy(busy),
        .sr_rd(sr_rd), .wr_allow(wr_allow), .cmd_ack(cmd_ack)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic send(input int c, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; sr_din = d;
        cmd_wren = (c == C_WREN); cmd_wrdi = (c == C_WRDI); cmd_rdsr = (c == C_RDSR);
        cmd_wrsr = (c == C_WRSR); cmd_write = (c == C_WRITE);
        @(negedge clk);
        g_ack = cmd_ack; g_allow = wr_allow; g_sr = sr_rd;
        cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0; cmd_wrsr = 0; cmd_write = 0;
    endtask

    task automatic rdsr(output logic [7:0] v);
        send(C_RDSR, '0, '0);
        v = g_sr;
    endtask

    task automatic run_cycle();
        @(negedge clk); busy = 1;
        repeat (3) @(negedge clk);
        busy = 0;
        @(negedge clk);
    endtask

    task automatic hard_reset();
        @(negedge clk); rst_n = 0; busy = 0; wp_n = 1; pwr_up = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    task automatic set_sr(input logic [7:0] d);
        send(C_WREN, '0, '0);
        send(C_WRSR, '0, d);
        run_cycle();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hard_reset();
        chk("R1 ack idle", {7'b0, cmd_ack}, 8'h00);
        rdsr(v);
        chk("R1 status after reset", v, 8'h00);
        chk("R10 rdsr ack", {7'b0, g_ack}, 8'h01);
        @(negedge clk);
        chk("R10 ack pulse ends", {7'b0, cmd_ack}, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        hard_reset();
        set_sr(8'h7C);
        rdsr(v);
        chk("R2 unused bits dropped", v, 8'h0C);
        set_sr(8'hF0);
        rdsr(v);
        chk("R2 lock bit at 7", v, 8'h80);
    endtask

    task automatic t_wen();
        logic [7:0] v;
        hard_reset();
        send(C_WREN, '0, '0);
        chk("R4 wren ack", {7'b0, g_ack}, 8'h01);
        rdsr(v);
        chk("R4 wen set", v, 8'h02);
        send(C_WRDI, '0, '0);
        rdsr(v);
        chk("R4 wrdi clears", v, 8'h00);
        send(C_WRITE, 12'h010, '0);
        chk("R5 array refused ack", {6'b0, g_ack, g_allow}, 8'h02);
        send(C_WRSR, '0, 8'h0C);
        chk("R5 status refused", {6'b0, g_ack, g_allow}, 8'h02);
        rdsr(v);
        chk("R5 status unchanged", v, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        hard_reset();
        @(negedge clk); busy = 1;
        rdsr(v);
        chk("R3 busy read FF", v, 8'hFF);
        chk("R3 rdsr acked in busy", {7'b0, g_ack}, 8'h01);
        send(C_WREN, '0, '0);
        chk("R3 wren ignored", {7'b0, g_ack}, 8'h00);
        @(negedge clk); busy = 0;
        @(negedge clk);
        rdsr(v);
        chk("R3 wen untouched", v, 8'h00);
    endtask

    task automatic t_cycle();
        logic [7:0] v;
        hard_reset();
        send(C_WREN, '0, '0);
        send(C_WRITE, 12'h010, '0);
        chk("R10 grant pulse", {6'b0, g_ack, g_allow}, 8'h03);
        @(negedge clk);
        chk("R10 allow pulse ends", {7'b0, wr_allow}, 8'h00);
        rdsr(v);
        chk("R11 pending reads FF", v, 8'hFF);
        send(C_WRDI, '0, '0);
        chk("R11 pending ignores wrdi", {7'b0, g_ack}, 8'h00);
        run_cycle();
        rdsr(v);
        chk("R11 finish clears wen", v, 8'h00);
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic exp_allow, input string tag);
        send(C_WREN, '0, '0);
        send(C_WRITE, a, '0);
        chk(tag, {7'b0, g_allow}, {7'b0, exp_allow});
        if (g_allow) run_cycle();
        else send(C_WRDI, '0, '0);
    endtask

    task automatic t_blocks();
        hard_reset();
        probe(12'hFFF, 1'b1, "R6 bp00 top open");
        set_sr(8'h04);
        probe(12'hBFF, 1'b1, "R6 bp01 below quarter");
        probe(12'hC00, 1'b0, "R6 bp01 quarter start");
        set_sr(8'h08);
        probe(12'h7FF, 1'b1, "R6 bp10 below half");
        probe(12'h800, 1'b0, "R6 bp10 half start");
        set_sr(8'h0C);
        probe(12'h000, 1'b0, "R6 bp11 bottom guarded");
    endtask

    task automatic t_hwp();
        logic [7:0] v;
        hard_reset();
        set_sr(8'h80);
        wp_n = 0;
        send(C_WREN, '0, '0);
        send(C_WRSR, '0, 8'h00);
        chk("R7 status locked", {6'b0, g_ack, g_allow}, 8'h02);
        rdsr(v);
        chk("R8 lock kept while pin low", v, 8'h82);
        send(C_WRITE, 12'h123, '0);
        chk("R7 array still writable", {7'b0, g_allow}, 8'h01);
        run_cycle();
        wp_n = 1;
        set_sr(8'h00);
        rdsr(v);
        chk("R8 lock cleared with pin high", v, 8'h00);
    endtask

    task automatic t_pwrup();
        logic [7:0] v;
        hard_reset();
        set_sr(8'h8C);
        send(C_WREN, '0, '0);
        rdsr(v);
        chk("R9 before power-up", v, 8'h8E);
        @(negedge clk); pwr_up = 1;
        @(negedge clk); pwr_up = 0;
        rdsr(v);
        chk("R9 nv kept wen cleared", v, 8'h8C);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_layout();
                t_wen();
                t_busy();
                t_cycle();
                t_blocks();
                t_hwp();
                t_pwrup();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog got=hung exp=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule